// File: doc/BRIEF.md
# Chunked Hamming Parity Generator

This block computes a single-error-correcting Hamming code over a stream of bytes, one code for each block of 256 bytes. A byte is taken on every clock on which the valid strobe is high. Each byte adds to two running parities. The line parity records which byte position holds the odd bits. The column parity records which bit positions within the bytes are odd. When the 256th byte of a block is accepted, the block latches the finished 22-bit parity word and pulses a done flag. It then restarts the accumulation for the next block without needing a gap.

The parity word is also turned into the 3-byte form that is written to the flash spare area. The word is shifted up by two places, inverted and kept to 24 bits. This stored code is offered in parallel. It is also sent as a three-beat byte sequence, most significant byte first, so that it can be appended directly to an outgoing spare-area stream. A clear strobe throws away a partly accumulated block before a new transfer starts.

Top module: `hecc_gen`

## Requirements
- R1: After exactly 256 accepted bytes, `done_o` is high for the single cycle after the edge that accepted the 256th byte. It is low at every other time, including while the block is being filled.
- R2: `parity_o[5:0]` is the column parity. For k in 0..2, bit 2k is the XOR of every data bit of the block whose bit position (0..7) has bit k equal to 0. Bit 2k+1 is the XOR of those whose position has bit k equal to 1.
- R3: `parity_o[21:6]` is the line parity. For k in 0..7, bit 6+2k is the XOR of all data bits in bytes whose index in the block (0..255) has bit k equal to 0. Bit 7+2k covers the bytes whose index has bit k equal to 1.
- R4: For a block that holds exactly one set bit, at byte index i and bit position j, the odd-numbered bits of the parity word spell j (bits 1,3,5) and i (bits 7,9,...,21), least significant first. The even-numbered bits are their complements. This is what lets a single flipped bit be located.
- R5: `code_o` equals the bitwise inverse of {parity_o, 2'b00}, taken over 24 bits. After reset it reads 24'hFFFFFF.
- R6: On the cycle `done_o` is high and the two cycles after it, `code_byte_vld_o` is high and `code_byte_o` carries code bits 23:16, then 15:8, then 7:0. At all other times `code_byte_vld_o` is low.
- R7: A high `clr_i` discards the bytes accumulated so far. If `vld_i` is high on that same cycle, the byte is taken as byte 0 of a fresh block.
- R8: A cycle with `vld_i` low changes neither the parity nor the byte count, whatever is on `data_i`.
- R9: Accumulation restarts after each block, so a block that starts on the very next cycle gets a parity word that depends only on its own bytes.
- R10: After reset, `parity_o` is 0 and `done_o` and `code_byte_vld_o` are low. `parity_o` then holds its value until the next block completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Discard the partial block |
| vld_i | input | 1 | Byte on `data_i` is valid this cycle |
| data_i | input | 8 | Data byte |
| parity_o | output | 22 | Latched parity word: line parity in bits 21:6, column parity in bits 5:0 |
| done_o | output | 1 | One-cycle pulse when a block's word is latched |
| code_o | output | 24 | Stored-format code of `parity_o` |
| code_byte_o | output | 8 | Serial stored code, high byte first |
| code_byte_vld_o | output | 1 | `code_byte_o` is valid |

## Verification
The bench sweeps a single set bit across every bit position at byte indices 0, 255 and each power of two. A swapped even/odd pair, or a line bit tied to the wrong index bit, shows up there as a wrong location code. Blocks interleaved with idle cycles that carry garbage data catch a design that accumulates bytes without checking the valid strobe. A clear in mid-block, and a clear on the same cycle as a valid byte, expose a design that keeps stale parity or drops the first byte of the new block. Back-to-back blocks and the three-beat emission catch a missed restart, a stretched done pulse and a reversed byte order.

// File: rtl/hecc_pkg.sv
// Shared constants for the chunked Hamming parity generator.
// Assumes byte-wide data; the bit-position index width follows from it.
package hecc_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int COL_W     = 2 * BIT_IDX_W;
endpackage

// File: rtl/hecc_col_par.sv
// Column-parity contribution of one byte, plus the byte's own parity.
// Purely combinational. Pair k: even slot = bits whose position has bit k
// clear, odd slot = bits whose position has bit k set.
module hecc_col_par
    import hecc_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    output logic [COL_W-1:0]  col_o,
    output logic              byte_par_o
);
    for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_pair
        logic [BYTE_W-1:0] hi_mask;
        // Mask of bit positions whose index has bit k set
        always_comb begin
            for (int b = 0; b < BYTE_W; b++) begin
                hi_mask[b] = ((b >> k) & 1) == 1;
            end
        end
        assign col_o[2*k]   = ^(data_i & ~hi_mask);
        assign col_o[2*k+1] = ^(data_i &  hi_mask);
    end

    assign byte_par_o = ^data_i;
endmodule

// File: rtl/hecc_line_par.sv
// Line-parity contribution of one byte at a given index in the block.
// Combinational. Pair k: even slot toggles when index bit k is clear,
// odd slot when it is set; both only if the byte's parity is odd.
module hecc_line_par #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               byte_par_i,
    output logic [2*IDX_W-1:0] line_o
);
    for (genvar k = 0; k < IDX_W; k++) begin : g_pair
        assign line_o[2*k]   = byte_par_i & ~idx_i[k];
        assign line_o[2*k+1] = byte_par_i &  idx_i[k];
    end
endmodule

// File: rtl/hecc_accum.sv
// Parity accumulator and byte counter for one block.
// Assumes contributions arrive pre-split by column/line logic and that the
// caller supplies the line contribution for the effective index idx_o.
// Latches the finished word and pulses done after the last byte.
module hecc_accum #(
    parameter int IDX_W = 8,
    parameter int PAR_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic [PAR_W-1:0] contrib_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o,
    output logic [PAR_W-1:0] word_next_o,
    output logic [PAR_W-1:0] word_o,
    output logic             done_o
);
    logic [IDX_W-1:0] cnt_q;
    logic [PAR_W-1:0] acc_q;
    logic [PAR_W-1:0] base;

    // Effective index and base: a clear restarts from zero this cycle
    always_comb begin
        idx_o       = clr_i ? '0 : cnt_q;
        base        = clr_i ? '0 : acc_q;
        word_next_o = vld_i ? (base ^ contrib_i) : base;
        last_o      = vld_i && (idx_o == {IDX_W{1'b1}});
    end

    // Count and accumulation state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (last_o) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (vld_i) begin
            cnt_q <= IDX_W'(idx_o + 1'b1);
            acc_q <= word_next_o;
        end else if (clr_i) begin
            cnt_q <= '0;
            acc_q <= '0;
        end
    end

    // Latched result and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last_o;
            if (last_o) begin
                word_o <= word_next_o;
            end
        end
    end

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !clr_i) |=> ($stable(cnt_q) && $stable(acc_q)));

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(word_o));
endmodule

// File: rtl/hecc_emit.sv
// Serialises a stored code as bytes, most significant byte first.
// Assumes a new load never arrives while a previous code is still going out.
module hecc_emit #(
    parameter int NBYTES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [8*NBYTES-1:0]   code_i,
    output logic [7:0]            byte_o,
    output logic                  vld_o
);
    localparam int CNT_W = $clog2(NBYTES + 1);

    logic [8*NBYTES-1:0] sh_q;
    logic [CNT_W-1:0]    left_q;

    // Shift register and remaining-beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sh_q   <= code_i;
            left_q <= CNT_W'(NBYTES);
        end else if (left_q != '0) begin
            sh_q   <= sh_q << 8;
            left_q <= left_q - 1'b1;
        end
    end

    assign byte_o = sh_q[8*NBYTES-1 -: 8];
    assign vld_o  = (left_q != '0);

    // R6
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (left_q == '0));
endmodule

// File: rtl/hecc_gen.sv
// Top of the chunked Hamming parity generator: 2^CHUNK_LOG2 bytes per code.
// Builds the per-byte contributions, accumulates them, and presents the
// latched word, its inverted/shifted stored form and a byte-serial copy.
module hecc_gen
    import hecc_pkg::*;
#(
    parameter int CHUNK_LOG2 = 8,
    localparam int PAR_W  = 2 * CHUNK_LOG2 + COL_W,
    localparam int CODE_W = PAR_W + 2,
    localparam int NBYTES = (CODE_W + 7) / 8,
    localparam int CODE_P = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [PAR_W-1:0]  parity_o,
    output logic              done_o,
    output logic [CODE_P-1:0] code_o,
    output logic [7:0]        code_byte_o,
    output logic              code_byte_vld_o
);
    logic [COL_W-1:0]        col_c;
    logic                    byte_par;
    logic [CHUNK_LOG2-1:0]   idx;
    logic [2*CHUNK_LOG2-1:0] line_c;
    logic                    last;
    logic [PAR_W-1:0]        word_next;
    logic [CODE_P-1:0]       code_next;

    function automatic logic [CODE_P-1:0] to_stored(input logic [PAR_W-1:0] w);
        logic [CODE_P-1:0] r;
        r = '0;
        r[CODE_W-1:0] = ~{w, 2'b00};
        return r;
    endfunction

    hecc_col_par u_col (
        .data_i     (data_i),
        .col_o      (col_c),
        .byte_par_o (byte_par)
    );

    hecc_line_par #(.IDX_W(CHUNK_LOG2)) u_line (
        .idx_i      (idx),
        .byte_par_i (byte_par),
        .line_o     (line_c)
    );

    hecc_accum #(.IDX_W(CHUNK_LOG2), .PAR_W(PAR_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .vld_i       (vld_i),
        .contrib_i   ({line_c, col_c}),
        .idx_o       (idx),
        .last_o      (last),
        .word_next_o (word_next),
        .word_o      (parity_o),
        .done_o      (done_o)
    );

    // Stored form of the word about to be latched, and of the latched word
    always_comb begin
        code_next = to_stored(word_next);
        code_o    = to_stored(parity_o);
    end

    hecc_emit #(.NBYTES(NBYTES)) u_emit (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (last),
        .code_i (code_next),
        .byte_o (code_byte_o),
        .vld_o  (code_byte_vld_o)
    );

    // R6
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (code_byte_vld_o && code_byte_o == code_o[CODE_P-1 -: 8]));
endmodule

// File: tb/hecc_gen_tb.sv
module hecc_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [21:0] parity_o;
    logic        done_o;
    logic [23:0] code_o;
    logic [7:0]  code_byte_o;
    logic        code_byte_vld_o;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0]  mem [256];
    logic [31:0] rng = 32'h1234_5678;
    bit finished = 0;

    always #2 clk = ~clk;

    hecc_gen u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .vld_i(vld), .data_i(din),
        .parity_o(parity_o), .done_o(done_o), .code_o(code_o),
        .code_byte_o(code_byte_o), .code_byte_vld_o(code_byte_vld_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    // Reference: toggle one column slot per bit position bit and one line slot per index bit
    function automatic logic [21:0] model();
        logic [21:0] w = '0;
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (mem[i][j]) begin
                    for (int k = 0; k < 3; k++) w[2*k + ((j >> k) & 1)] ^= 1'b1;
                    for (int k = 0; k < 8; k++) w[6 + 2*k + ((i >> k) & 1)] ^= 1'b1;
                end
            end
        end
        return w;
    endfunction

    function automatic logic [23:0] stored(input logic [21:0] w);
        return ~{w, 2'b00};
    endfunction

    task automatic fill_rand();
        for (int i = 0; i < 256; i++) mem[i] = nxt()[7:0];
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld = 1'b1; clr = 1'b0; din = nxt()[7:0];
        end
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic run_chunk(input bit gaps, input bit b2b, input bit clr_first,
                             input string req);
        bit early = 0;
        logic [21:0] ew;
        logic [23:0] ec;
        ew = model();
        ec = stored(ew);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i > 0 && done_o) early = 1;
            vld = 1'b1; din = mem[i]; clr = (i == 0) && clr_first;
            if (gaps && i < 255 && nxt()[0]) begin
                @(negedge clk);
                if (done_o) early = 1;
                vld = 1'b0; clr = 1'b0; din = ~mem[i] ^ 8'h5A;
            end
        end
        @(posedge clk);
        #1;
        chk(done_o === 1'b1, "R1 done after 256th byte", 32'(done_o), 32'd1);
        chk(!early, "R1 no early done", 32'(early), 32'd0);
        chk(parity_o === ew, req, 32'(parity_o), 32'(ew));
        chk(code_o === ec, "R5 stored code", 32'(code_o), 32'(ec));
        chk(code_byte_vld_o && code_byte_o === ec[23:16], "R6 beat 0",
            32'(code_byte_o), 32'(ec[23:16]));
        if (!b2b) begin
            @(negedge clk);
            vld = 1'b0; clr = 1'b0;
            @(posedge clk); #1;
            chk(!done_o, "R1 done one cycle", 32'(done_o), 32'd0);
            chk(code_byte_vld_o && code_byte_o === ec[15:8], "R6 beat 1",
                32'(code_byte_o), 32'(ec[15:8]));
            @(posedge clk); #1;
            chk(code_byte_vld_o && code_byte_o === ec[7:0], "R6 beat 2",
                32'(code_byte_o), 32'(ec[7:0]));
            @(posedge clk); #1;
            chk(!code_byte_vld_o, "R6 emission ends", 32'(code_byte_vld_o), 32'd0);
            chk(parity_o === ew, "R10 parity holds", 32'(parity_o), 32'(ew));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(parity_o === 22'd0, "R10 reset parity", 32'(parity_o), 32'd0);
        chk(code_o === 24'hFFFFFF, "R5 reset code", 32'(code_o), 32'hFFFFFF);
        chk(!done_o && !code_byte_vld_o, "R10 reset flags",
            32'({done_o, code_byte_vld_o}), 32'd0);

        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        run_chunk(0, 0, 0, "R2 R3 all zero");
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        run_chunk(0, 0, 0, "R2 R3 all ones");
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        run_chunk(0, 0, 0, "R2 R3 ramp");
        fill_rand();
        run_chunk(1, 0, 0, "R8 gaps with garbage");

        // R4 single-bit location sweep
        for (int q = 0; q < 10; q++) begin
            for (int j = 0; j < 8; j++) begin
                int idx;
                logic [21:0] loc;
                idx = (q == 0) ? 0 : (q == 9) ? 255 : (1 << (q - 1));
                for (int i = 0; i < 256; i++) mem[i] = 8'h00;
                mem[idx] = 8'(1 << j);
                run_chunk(0, 0, 0, "R2 R3 single bit");
                for (int k = 0; k < 3; k++) begin
                    loc[2*k+1] = ((j >> k) & 1) == 1;
                    loc[2*k]   = ((j >> k) & 1) == 0;
                end
                for (int k = 0; k < 8; k++) begin
                    loc[7+2*k] = ((idx >> k) & 1) == 1;
                    loc[6+2*k] = ((idx >> k) & 1) == 0;
                end
                chk(parity_o === loc, "R4 location code", 32'(parity_o), 32'(loc));
            end
        end

        // R7 clear on its own discards a partial block
        send_partial(100);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        fill_rand();
        run_chunk(0, 0, 0, "R7 clear alone");

        // R7 clear together with a valid byte
        send_partial(50);
        fill_rand();
        run_chunk(1, 0, 1, "R7 clear with valid");

        // R9 back-to-back blocks
        fill_rand();
        run_chunk(0, 1, 0, "R9 first block");
        fill_rand();
        run_chunk(0, 0, 0, "R9 second block");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule